// File: doc/BRIEF.md
# Four-Phase Handshake Sequencer

This block couples an upstream (left) channel to a downstream (right) channel using four-phase return-to-zero signalling. A request arriving on the left starts a complete request/acknowledge/release/release cycle on the right. Only after that right-side cycle is fully back to zero does the block acknowledge the left side. It then waits for the left request to drop, withdraws its acknowledge, and is ready for the next request. The right-side handshake is therefore fully nested inside the left-side one.

The block is modelled as clocked synchronous logic. Both request and acknowledge inputs are sampled as levels on the rising clock edge, and every output comes straight from a flop. A single internal phase bit separates the "request the right side" state from the "right side has answered" state. Without this bit the conditions for raising and for lowering the right request would overlap. The bit is set when the right acknowledge is seen high and cleared when the left request is seen low. The two outputs follow from this bit and the sampled inputs.

A sticky error flag records any environment move that breaks the protocol. Only reset clears it. Reset is asynchronous and active low.

Top module: `hsq_seq_elem`

## Requirements
- R1: While reset is asserted, `rreq_o`, `lack_o` and `perr_o` are all low.
- R2: With `lreq_i` and `rack_i` held low after reset, `rreq_o` and `lack_o` stay low.
- R3: When `lreq_i` is sampled high while the phase bit is clear, `rreq_o` is high after that same clock edge.
- R4: The first edge that samples `rack_i` high sets the phase bit, and `rreq_o` stays high through that edge. `rreq_o` goes low at the following edge.
- R5: The first edge that samples `rack_i` low while the phase bit is set drives `lack_o` high. `lack_o` stays low while `rack_i` is high.
- R6: The edge that samples `lreq_i` low clears the phase bit, and `lack_o` stays high through that edge. `lack_o` goes low at the next edge.
- R7: `rreq_o` and `lack_o` are never high at the same time.
- R8: With a compliant environment, the channel signals change in this repeating order: left request up, right request up, right ack up, right request down, right ack down, left ack up, left request down, left ack down.
- R9: If `rack_i` rises while `rreq_o` is low, `perr_o` is high after that edge.
- R10: If `lreq_i` falls while `lack_o` is low, `perr_o` is high after that edge.
- R11: If `rack_i` falls while `rreq_o` is high, or `lreq_i` rises while `lack_o` is high, `perr_o` is high after that edge.
- R12: Once high, `perr_o` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| lreq_i | input | 1 | Left channel request |
| lack_o | output | 1 | Left channel acknowledge |
| rreq_o | output | 1 | Right channel request |
| rack_i | input | 1 | Right channel acknowledge |
| perr_o | output | 1 | Sticky protocol violation flag |

## Verification
A wrong phase bit shows up at the ports within one or two edges. If the bit sets too early or never sets, `rreq_o` falls too soon or is held high too long. That is caught by the exact edge counts checked after each acknowledge move. If the bit clears too late or never clears, `lack_o` lingers past the second edge after the left request drops. It can also leave the next left request unanswered. A bad ordering rule produces an out-of-sequence event or overlapping `rreq_o`/`lack_o`, which the event-order monitor flags in the same half cycle.

// File: rtl/hsq_pkg.sv
package hsq_pkg;

    // Registered state of the sequencer
    typedef struct packed {
        logic phase;      // set once the right side has answered
        logic rreq;       // right request output
        logic lack;       // left acknowledge output
        logic lreq_prev;  // left request seen at previous edge
        logic rack_prev;  // right acknowledge seen at previous edge
        logic perr;       // sticky violation flag
    } hsq_state_t;

    localparam hsq_state_t HSQ_RESET = '{default: 1'b0};

endpackage

// File: rtl/hsq_phase_bit.sv
// Next value of the phase bit: set by a high right acknowledge,
// cleared by a low left request, held otherwise.
module hsq_phase_bit (
    input  logic phase_q,
    input  logic lreq,
    input  logic rack,
    output logic phase_d
);
    always_comb begin
        if (rack) begin
            phase_d = 1'b1;
        end else if (!lreq) begin
            phase_d = 1'b0;
        end else begin
            phase_d = phase_q;
        end
    end
endmodule

// File: rtl/hsq_out_rules.sv
// Output rules driven by the phase bit and the sampled inputs.
module hsq_out_rules (
    input  logic phase_q,
    input  logic lreq,
    input  logic rack,
    output logic rreq_d,
    output logic lack_d
);
    logic rreq_up;
    logic rreq_down;
    logic lack_up;
    logic lack_down;

    always_comb begin
        rreq_up   = !phase_q && lreq;
        rreq_down = phase_q || !lreq;
        lack_up   = phase_q && !rack;
        lack_down = !phase_q || rack;
        rreq_d    = rreq_up && !rreq_down;
        lack_d    = lack_up && !lack_down;
    end
endmodule

// File: rtl/hsq_proto_mon.sv
// Detects environment moves that break the four-phase protocol.
module hsq_proto_mon (
    input  logic lreq,
    input  logic rack,
    input  logic lreq_prev,
    input  logic rack_prev,
    input  logic rreq_q,
    input  logic lack_q,
    input  logic perr_q,
    output logic perr_d
);
    logic rack_rise;
    logic rack_fall;
    logic lreq_rise;
    logic lreq_fall;
    logic bad;

    always_comb begin
        rack_rise = rack && !rack_prev;
        rack_fall = !rack && rack_prev;
        lreq_rise = lreq && !lreq_prev;
        lreq_fall = !lreq && lreq_prev;
        bad = (rack_rise && !rreq_q) ||
              (rack_fall && rreq_q)  ||
              (lreq_fall && !lack_q) ||
              (lreq_rise && lack_q);
        perr_d = perr_q || bad;
    end
endmodule

// File: rtl/hsq_seq_elem.sv
module hsq_seq_elem
    import hsq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lreq_i,
    output logic lack_o,
    output logic rreq_o,
    input  logic rack_i,
    output logic perr_o
);
    hsq_state_t st_q;
    hsq_state_t st_d;

    logic phase_d;
    logic rreq_d;
    logic lack_d;
    logic perr_d;

    hsq_phase_bit u_phase (
        .phase_q (st_q.phase),
        .lreq    (lreq_i),
        .rack    (rack_i),
        .phase_d (phase_d)
    );

    hsq_out_rules u_rules (
        .phase_q (st_q.phase),
        .lreq    (lreq_i),
        .rack    (rack_i),
        .rreq_d  (rreq_d),
        .lack_d  (lack_d)
    );

    hsq_proto_mon u_mon (
        .lreq      (lreq_i),
        .rack      (rack_i),
        .lreq_prev (st_q.lreq_prev),
        .rack_prev (st_q.rack_prev),
        .rreq_q    (st_q.rreq),
        .lack_q    (st_q.lack),
        .perr_q    (st_q.perr),
        .perr_d    (perr_d)
    );

    always_comb begin
        st_d           = st_q;
        st_d.phase     = phase_d;
        st_d.rreq      = rreq_d;
        st_d.lack      = lack_d;
        st_d.lreq_prev = lreq_i;
        st_d.rack_prev = rack_i;
        st_d.perr      = perr_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= HSQ_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign rreq_o = st_q.rreq;
    assign lack_o = st_q.lack;
    assign perr_o = st_q.perr;
endmodule

// File: rtl/hsq_seq_chk.sv
module hsq_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic lreq_i,
    input logic lack_o,
    input logic rreq_o,
    input logic rack_i,
    input logic perr_o
);
    // R7: outputs never overlap
    assert_out_mutex_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rreq_o && lack_o));

    // R3: right request only rises from a sampled left request
    assert_rreq_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rreq_o) |-> $past(lreq_i));

    // R5: left ack only rises when right ack was sampled low
    assert_lack_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lack_o) |-> !$past(rack_i));

    // R6: left ack only falls after left request dropped (or a violation)
    assert_lack_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lack_o) |-> (!$past(lreq_i) || perr_o));

    // R12: violation flag is sticky
    assert_perr_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(perr_o) |-> perr_o);
endmodule

bind hsq_seq_elem hsq_seq_chk chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .lreq_i (lreq_i),
    .lack_o (lack_o),
    .rreq_o (rreq_o),
    .rack_i (rack_i),
    .perr_o (perr_o)
);

// File: tb/hsq_seq_elem_tb_top.sv
`timescale 1ns/1ps
module hsq_seq_elem_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lreq = 1'b0;
    logic rack = 1'b0;
    logic lack;
    logic rreq;
    logic perr;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    bit mon_en = 1'b0;
    int ev_idx = 0;
    logic [3:0] prev_sig = '0;

    always #2.5 clk = ~clk;

    hsq_seq_elem dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .lreq_i (lreq),
        .lack_o (lack),
        .rreq_o (rreq),
        .rack_i (rack),
        .perr_o (perr)
    );

    task automatic chk(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Expected code of the k-th event in the cycle (R8)
    // bits: {lreq, rreq, rack, lack}; code = signal index*2 + (falling?1:0)
    function automatic int exp_event(input int k);
        case (k % 8)
            0: return 0;  // left request up
            1: return 2;  // right request up
            2: return 4;  // right ack up
            3: return 3;  // right request down
            4: return 5;  // right ack down
            5: return 6;  // left ack up
            6: return 1;  // left request down
            default: return 7; // left ack down
        endcase
    endfunction

    // Event-order monitor (R8, R7), samples 1 ns after each clock edge
    always begin
        @(clk);
        #1;
        begin
            logic [3:0] cur;
            logic [3:0] chg;
            cur = {lreq, rreq, rack, lack};
            chg = cur ^ prev_sig;
            if (!mon_en) begin
                ev_idx = 0;
            end else begin
                if (rreq && lack) chk(1'b1, 1'b0, "R7 overlap");
                if ($countones(chg) > 1) begin
                    chk(1'b1, 1'b0, "R8 simultaneous change");
                end else if (chg != 0) begin
                    int sig;
                    int code;
                    sig = chg[3] ? 0 : chg[2] ? 1 : chg[1] ? 2 : 3;
                    code = sig * 2 + ((cur & chg) == 0 ? 1 : 0);
                    n_chk++;
                    if (code != exp_event(ev_idx)) begin
                        n_err++;
                        $display("FAIL R8: actual=%0d expected=%0d event %0d", code, exp_event(ev_idx), ev_idx);
                    end
                    ev_idx++;
                end
            end
            prev_sig = cur;
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        mon_en = 1'b0;
        lreq = 1'b0;
        rack = 1'b0;
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        step();
    endtask

    // One compliant transaction with delays
    task automatic txn(input int d1, input int d2, input int d3);
        lreq = 1'b1;
        step();
        chk(rreq, 1'b1, "R3 rreq up");
        chk(lack, 1'b0, "R3 lack low");
        for (int i = 0; i < d1; i++) begin
            step();
            chk(rreq, 1'b1, "R3 rreq held");
        end
        rack = 1'b1;
        step();
        chk(rreq, 1'b1, "R4 rreq held one edge");
        step();
        chk(rreq, 1'b0, "R4 rreq down");
        for (int i = 0; i < d2; i++) begin
            step();
            chk(lack, 1'b0, "R5 lack low while rack high");
        end
        rack = 1'b0;
        step();
        chk(lack, 1'b1, "R5 lack up");
        for (int i = 0; i < d3; i++) begin
            step();
            chk(lack, 1'b1, "R5 lack held");
        end
        lreq = 1'b0;
        step();
        chk(lack, 1'b1, "R6 lack held one edge");
        step();
        chk(lack, 1'b0, "R6 lack down");
        chk(perr, 1'b0, "R12 no error in compliant run");
    endtask

    initial begin
        process::self().srandom(32'd1234);
        rst_n = 1'b0;
        step();
        chk(rreq, 1'b0, "R1 rreq");
        chk(lack, 1'b0, "R1 lack");
        chk(perr, 1'b0, "R1 perr");
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            step();
            chk(rreq | lack, 1'b0, "R2 idle");
        end
        mon_en = 1'b1;
        txn(0, 0, 0);
        txn(3, 1, 2);
        for (int t = 0; t < 200; t++) begin
            txn(int'($urandom_range(0, 5)), int'($urandom_range(0, 5)), int'($urandom_range(0, 5)));
        end
        chk(ev_idx % 8 == 0, 1'b1, "R8 whole cycles");
        mon_en = 1'b0;

        // R9: right ack rises with no right request
        do_reset();
        rack = 1'b1;
        step();
        chk(perr, 1'b1, "R9 rack rise while rreq low");
        rack = 1'b0;
        for (int i = 0; i < 4; i++) step();
        chk(perr, 1'b1, "R12 sticky");
        do_reset();
        chk(perr, 1'b0, "R12 cleared by reset");

        // R10: left request dropped before left ack
        lreq = 1'b1;
        step();
        lreq = 1'b0;
        step();
        chk(perr, 1'b1, "R10 early lreq fall");
        do_reset();

        // R11: right ack dropped while right request high
        lreq = 1'b1;
        step();
        rack = 1'b1;
        step();
        rack = 1'b0;
        step();
        chk(perr, 1'b1, "R11 rack fall while rreq high");
        do_reset();

        // R11: left request raised while left ack high
        lreq = 1'b1;
        step();
        rack = 1'b1;
        step();
        step();
        rack = 1'b0;
        step();
        chk(lack, 1'b1, "R5 lack up before violation");
        lreq = 1'b0;
        step();
        chk(perr, 1'b0, "R11 no error yet");
        lreq = 1'b1;
        step();
        chk(perr, 1'b1, "R11 lreq rise while lack high");

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule